// File: doc/BRIEF.md
# Paged DMA descriptor chain generator

This block turns a single transfer request into the ordered list of descriptors that a DMA channel walks through. A request carries a byte address, a byte length and a direction. The block cuts the transfer at page boundaries and hands the descriptors out one at a time over a valid/ready pair. Each descriptor carries a command code, a byte count, an address and a set of control flags.

If the start address is not page aligned and the transfer runs past the end of that page, a short first descriptor covers only the bytes up to the next page boundary. Full-page descriptors follow for as long as more than one page remains. One "last" descriptor carries the remaining bytes, and a stop descriptor closes the chain. Addresses are treated as physical. A request that would need more descriptor slots than the channel's descriptor storage holds is refused as a whole and is flagged as an error.

The block accepts a new request only while it is idle. A one-cycle done pulse marks the end of a chain, and it also marks the refusal of an oversized request.

Top module: `dma_chain_gen`

## Requirements
- R1: After reset, `desc_valid_o`, `done_o` and `err_o` are all 0.
- R2: If the start address has a nonzero page offset and the length is greater than (page size − offset), the first descriptor is a "more" descriptor with count (page size − offset) at the start address.
- R3: If the start address has a nonzero page offset and the length is at most (page size − offset), the data part of the chain is a single "last" descriptor at the start address with count equal to the length.
- R4: Once the address is page aligned, a "more" descriptor with count equal to the page size is produced while the remaining length is strictly greater than the page size. Each descriptor's address equals the previous descriptor's address plus the previous count.
- R5: The final data descriptor is a "last" descriptor whose count is the remaining length, which lies between 1 and the page size for a nonzero request.
- R6: Command encoding on `desc_cmd_o`: write-more = 0, write-last = 1, read-more = 2, read-last = 3, stop = 7. Read requests (`rd_i` = 1) use only 2 and 3 for data, and write requests use only 0 and 1.
- R7: A stop descriptor with count 0 and address 0 always directly follows the "last" descriptor.
- R8: `desc_flags_o` (interrupt in bits 1:0, wait in bits 3:2, branch in bits 5:4, where 00 means never) is 0 on every descriptor.
- R9: One descriptor is consumed per cycle in which both `desc_valid_o` and `desc_ready_i` are high. While `desc_valid_o` is high and `desc_ready_i` is low, the descriptor fields hold their values.
- R10: `done_o` is high for exactly one cycle, in the cycle after the stop descriptor is accepted. At that point `desc_valid_o` is 0.
- R11: A request whose chain, counting the stop descriptor, exceeds `MAX_DESC` entries produces no descriptor. It sets `err_o` and gives a `done_o` pulse in the next cycle. `err_o` stays set until the next accepted request clears it.
- R12: A zero-length request produces one "last" descriptor with count 0 at the start address, followed by the stop descriptor.
- R13: A `start_i` pulse while a chain is being emitted is ignored, and the chain in progress continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request pulse, taken only when idle |
| addr_i | input | ADDR_W | Transfer start byte address |
| len_i | input | LEN_W | Transfer length in bytes |
| rd_i | input | 1 | 1 = read (input) transfer, 0 = write (output) |
| desc_ready_i | input | 1 | Consumer accepts the current descriptor |
| desc_valid_o | output | 1 | A descriptor is presented |
| desc_cmd_o | output | 3 | Descriptor command code |
| desc_count_o | output | log2(PAGE_BYTES)+1 | Descriptor byte count |
| desc_addr_o | output | ADDR_W | Descriptor byte address |
| desc_flags_o | output | 6 | Interrupt/wait/branch control fields |
| done_o | output | 1 | One-cycle end-of-request pulse |
| err_o | output | 1 | Request refused for exceeding the descriptor limit |

## Verification
The bench sweeps every page offset of a 16-byte-page configuration against every length from 0 up past the descriptor limit, and it applies random back-pressure. A design that skipped the short head descriptor, or that emitted one even when the transfer fits in its page, would show a wrong count at the first handshake. A design that compared with ≥ instead of > against the page size would turn an exact final page into a "more" descriptor followed by a zero-count "last" descriptor. Lengths just on either side of the limit catch an off-by-one in the slot count, which shows up as a truncated chain or as a wrongly raised error. A start pulse injected mid-chain checks that a busy generator does not restart.

// File: rtl/dma_chain_gen.sv
module dma_chain_gen #(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 20,
  parameter int PAGE_BYTES = 4096,
  parameter int MAX_DESC   = 20,
  localparam int PB = $clog2(PAGE_BYTES),
  localparam int CW = PB + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              rd_i,
  input  logic              desc_ready_i,
  output logic              desc_valid_o,
  output logic [2:0]        desc_cmd_o,
  output logic [CW-1:0]     desc_count_o,
  output logic [ADDR_W-1:0] desc_addr_o,
  output logic [5:0]        desc_flags_o,
  output logic              done_o,
  output logic              err_o
);
  localparam logic [LEN_W-1:0] PAGE_L  = LEN_W'(PAGE_BYTES);
  localparam logic [LEN_W:0]   PAGE_M1 = (LEN_W+1)'(PAGE_BYTES - 1);
  localparam logic [2:0]       CMD_STOP = 3'd7;

  logic              busy, stop_ph, rd_q;
  logic [ADDR_W-1:0] cur;
  logic [LEN_W-1:0]  rem;

  // Current descriptor, derived from the walk state
  wire [PB-1:0]    off       = cur[PB-1:0];
  wire [LEN_W-1:0] rest      = PAGE_L - LEN_W'(off);
  wire             head      = (off != '0) && (rem > rest);
  wire             full      = !head && (rem > PAGE_L);
  wire             is_last   = !head && !full;
  wire [LEN_W-1:0] cnt_l     = head ? rest : (full ? PAGE_L : rem);

  assign desc_valid_o = busy;
  assign desc_cmd_o   = stop_ph ? CMD_STOP : {1'b0, rd_q, is_last};
  assign desc_count_o = stop_ph ? '0 : cnt_l[CW-1:0];
  assign desc_addr_o  = stop_ph ? '0 : cur;
  assign desc_flags_o = 6'b00_00_00;

  // Slot count for an incoming request: head + data pages + stop
  wire [PB-1:0]    s_off  = addr_i[PB-1:0];
  wire [LEN_W-1:0] s_rest = PAGE_L - LEN_W'(s_off);
  wire             s_head = (s_off != '0) && (len_i > s_rest);
  wire [LEN_W-1:0] s_rem  = s_head ? len_i - s_rest : len_i;
  wire [LEN_W:0]   s_pg   = ({1'b0, s_rem} + PAGE_M1) >> PB;
  wire [LEN_W:0]   s_data = (s_rem == '0) ? (LEN_W+1)'(1) : s_pg;
  wire [LEN_W+1:0] s_need = {1'b0, s_data} + (LEN_W+2)'(s_head) + (LEN_W+2)'(1);
  wire             s_ovf  = s_need > (LEN_W+2)'(MAX_DESC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; stop_ph <= 1'b0; rd_q <= 1'b0;
      cur <= '0; rem <= '0; done_o <= 1'b0; err_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (!busy) begin
        if (start_i) begin
          if (s_ovf) begin
            err_o  <= 1'b1;
            done_o <= 1'b1;
          end else begin
            err_o   <= 1'b0;
            busy    <= 1'b1;
            stop_ph <= 1'b0;
            cur     <= addr_i;
            rem     <= len_i;
            rd_q    <= rd_i;
          end
        end
      end else if (desc_ready_i) begin
        if (stop_ph) begin
          busy   <= 1'b0;
          done_o <= 1'b1;
        end else if (is_last) begin
          stop_ph <= 1'b1;
        end else begin
          cur <= cur + ADDR_W'(cnt_l);
          rem <= rem - cnt_l;
        end
      end
    end
  end

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid_o && !desc_ready_i |=> desc_valid_o && $stable(desc_cmd_o)
      && $stable(desc_count_o) && $stable(desc_addr_o));

  assert_in_page_R4: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid_o && desc_cmd_o != CMD_STOP |->
      (CW+1)'(desc_addr_o[PB-1:0]) + (CW+1)'(desc_count_o) <= (CW+1)'(PAGE_BYTES));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_done_after_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid_o && desc_ready_i && desc_cmd_o == CMD_STOP |=> done_o && !desc_valid_o);

  assert_no_emit_on_err_R11: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid_o |-> !err_o);

  assert_stop_after_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid_o && desc_ready_i && desc_cmd_o[0] && desc_cmd_o != CMD_STOP
      |=> desc_valid_o && desc_cmd_o == CMD_STOP);
endmodule

// File: tb/test_dma_chain_gen.sv
`timescale 1ns/1ps
module test_dma_chain_gen;
  localparam int P = 16;
  localparam int MAXD = 6;
  localparam int LW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, rd = 1'b0, ready = 1'b0;
  logic [31:0] addr = '0;
  logic [LW-1:0] len = '0;
  logic valid, done, err;
  logic [2:0] cmd;
  logic [4:0] count;
  logic [31:0] daddr;
  logic [5:0] flags;

  int compared = 0, mismatched = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #4 clk = ~clk;

  dma_chain_gen #(.ADDR_W(32), .LEN_W(LW), .PAGE_BYTES(P), .MAX_DESC(MAXD)) i_dma_chain_gen (
    .clk(clk), .rst_n(rst_n), .start_i(start), .addr_i(addr), .len_i(len), .rd_i(rd),
    .desc_ready_i(ready), .desc_valid_o(valid), .desc_cmd_o(cmd), .desc_count_o(count),
    .desc_addr_o(daddr), .desc_flags_o(flags), .done_o(done), .err_o(err));

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  int e_cmd[32], e_cnt[32], e_kind[32];
  logic [31:0] e_adr[32];

  task automatic run_req(input logic [31:0] a0, input int l0, input bit r, input bit inject);
    int n = 0, k = 0, off, rr;
    logic [31:0] a = a0;
    bit injected = 0;
    rr = l0;
    off = int'(a0 % P);
    // kind: 2 head (R2), 4 full (R4), 5 last (R5/R3/R12), 7 stop (R7)
    if (off != 0 && rr > P - off) begin
      e_cmd[n] = r ? 2 : 0; e_cnt[n] = P - off; e_adr[n] = a; e_kind[n] = 2; n++;
      a += 32'(P - off); rr -= P - off;
    end
    while (rr > P) begin
      e_cmd[n] = r ? 2 : 0; e_cnt[n] = P; e_adr[n] = a; e_kind[n] = 4; n++;
      a += 32'(P); rr -= P;
    end
    e_cmd[n] = r ? 3 : 1; e_cnt[n] = rr; e_adr[n] = a; e_kind[n] = 5; n++;
    e_cmd[n] = 7; e_cnt[n] = 0; e_adr[n] = 0; e_kind[n] = 7; n++;

    @(negedge clk);
    start = 1'b1; addr = a0; len = LW'(l0); rd = r; ready = 1'b0;
    @(negedge clk);
    start = 1'b0;
    if (n > MAXD) begin
      check(done && err && !valid, "R11 overflow refused", {61'd0, done, err, valid}, 64'd6);
      @(negedge clk);
      check(!done && err && !valid, "R11 err held, no descriptor", {61'd0, done, err, valid}, 64'd2);
      return;
    end
    check(!err && valid, "R11 err cleared by accepted request", {62'd0, err, valid}, 64'd1);
    while (k < n) begin
      if (inject && k == 1 && !injected) begin
        start = 1'b1; addr = 32'h0; len = '0; rd = ~r; injected = 1;
      end else start = 1'b0;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      ready = lfsr[0] | lfsr[3];
      #1;
      if (!valid) begin
        check(0, "R9 valid dropped mid-chain", 64'd0, 64'd1);
        k = n;
      end else if (ready) begin
        string tag;
        case (e_kind[k])
          2: tag = "R2 head descriptor";
          4: tag = inject ? "R13 chain kept after busy start" : "R4 full-page descriptor";
          5: tag = (l0 == 0) ? "R12 zero-length last" : ((off != 0 && n == 2) ? "R3 fits-in-page last" : "R5 last descriptor");
          default: tag = "R7 stop descriptor";
        endcase
        check(int'(cmd) == e_cmd[k] && int'(count) == e_cnt[k] && daddr == e_adr[k] && flags == 6'd0,
              $sformatf("%s (R6 cmd, R8 flags) #%0d", tag, k),
              {23'd0, flags, cmd, count, daddr}, {29'd0, 3'(e_cmd[k]), 5'(e_cnt[k]), e_adr[k]});
        k++;
      end
      @(negedge clk);
    end
    start = 1'b0; ready = 1'b0;
    check(done && !valid, "R10 done after stop", {62'd0, done, valid}, 64'd2);
    @(negedge clk);
    check(!done, "R10 done one cycle", {63'd0, done}, 64'd0);
  endtask

  initial begin
    #1_600_000;
    mismatched++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #3;
    check(!valid && !done && !err, "R1 reset state", {61'd0, valid, done, err}, 64'd0);
    #20 rst_n = 1'b1;
    @(negedge clk);
    check(!valid && !done && !err, "R1 after reset", {61'd0, valid, done, err}, 64'd0);
    for (int off = 0; off < P; off++) begin
      for (int l = 0; l <= 100; l++) begin
        run_req(32'h1234_5600 + 32'(off) + 32'(l << 8), l, (l + off) % 2 == 1,
                off == 3 && l == 50);
      end
    end
    run_req(32'hFFFF_FFF0, 64, 1'b0, 1'b0);
    run_req(32'h0000_0005, 0, 1'b1, 1'b0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule